// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a processor core whose register numbering stays fixed while the storage behind some of the upper numbers moves with a 2-bit processor mode. It has two combinational read ports and one clocked write port, each addressed by a 4-bit register number. Each access is steered either to the shared user copy of the register or to a copy private to the current mode. The fast-interrupt mode has private copies of registers 8 to 14. The interrupt and supervisor modes have private copies of registers 13 and 14 only.

A second write port, the link port, carries its own target mode. Exception entry uses it to load register 14 of the mode being entered in the same cycle in which the core switches mode, whatever mode the core is in at that moment. Register number 15 holds the program counter, which is kept outside this block. Reads of it return a value supplied from outside, and writes to it are passed out unchanged.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every stored register reads as zero in every mode.
- R2: Registers 0 to 7 are a single copy shared by all four modes. A write in any mode is visible in every mode.
- R3: The mode encoding is 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor. In mode 1, registers 8 to 12 use private storage. In modes 0, 2 and 3 they use the user copies.
- R4: Registers 13 and 14 each have one copy per mode. A write to either register in one mode leaves that register unchanged in the other three modes.
- R5: Both read ports are combinational. A read of a physical register written in the same cycle returns the old value, and the new value appears after the clock edge.
- R6: The link port writes register 14 of the mode given on `lnk_mode`, regardless of `mode`. It can do this in the same cycle as an unrelated normal write, and both writes take effect.
- R7: When the normal write and the link write target the same physical register in one cycle, the link data is stored.
- R8: A read of register 15 returns `pc_value`. A write to register 15 raises `pc_wr_en` with `pc_wr_data` equal to `wr_data` in the same cycle and changes no stored register. `pc_wr_en` stays low for writes to other registers.
- R9: With both write enables low, no stored register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Current processor mode |
| rd_a_sel | input | 4 | Register number for read port A |
| rd_a_data | output | DW | Read port A data |
| rd_b_sel | input | 4 | Register number for read port B |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_sel | input | 4 | Normal write register number |
| wr_data | input | DW | Normal write data |
| lnk_en | input | 1 | Link write enable |
| lnk_mode | input | 2 | Mode whose register 14 the link port writes |
| lnk_data | input | DW | Link write data |
| pc_value | input | DW | Program counter value returned for register 15 reads |
| pc_wr_en | output | 1 | Write to register 15 requested |
| pc_wr_data | output | DW | Data for the register 15 write |

## Verification
Two functions can fall in the same cycle: a normal write and a link write. The bench fires both in one cycle in two ways. In the first case the targets differ: a user-mode write to register 2 together with a link write to interrupt register 14, and both results are read back in the following cycles. In the second case the targets collide: a supervisor-mode write to register 14 together with a link write to supervisor register 14, where only the link data may survive. A read launched in the same cycle as a write is also checked, first before the edge, where it must show the old value, and then after the edge.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    typedef enum logic [1:0] {
        MODE_USR = 2'd0,
        MODE_FIQ = 2'd1,
        MODE_IRQ = 2'd2,
        MODE_SVC = 2'd3
    } cpu_mode_e;

    localparam int ARCH_W     = 4;
    localparam int PC_NUM     = 15;
    localparam int FIQ_LO     = 8;
    localparam int SP_NUM     = 13;
    localparam int LR_NUM     = 14;
    localparam int USR_SLOTS  = PC_NUM;               // user R0..R14
    localparam int FIQ_SLOTS  = PC_NUM - FIQ_LO;      // FIQ R8..R14
    localparam int PRIV_SLOTS = PC_NUM - SP_NUM;      // R13, R14
    localparam int FIQ_BASE   = USR_SLOTS;
    localparam int IRQ_BASE   = FIQ_BASE + FIQ_SLOTS;
    localparam int SVC_BASE   = IRQ_BASE + PRIV_SLOTS;
    localparam int PHYS_SLOTS = SVC_BASE + PRIV_SLOTS;
    localparam int SLOT_W     = $clog2(PHYS_SLOTS);

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [ARCH_W-1:0] rnum_t;

    // Physical slot behind an architectural number in a given mode.
    function automatic slot_t map_slot(input cpu_mode_e m, input rnum_t n);
        int idx;
        idx = int'(n);
        if (n >= rnum_t'(FIQ_LO) && n < rnum_t'(PC_NUM)) begin
            unique case (m)
                MODE_FIQ: idx = FIQ_BASE + int'(n) - FIQ_LO;
                MODE_IRQ: if (n >= rnum_t'(SP_NUM)) idx = IRQ_BASE + int'(n) - SP_NUM;
                MODE_SVC: if (n >= rnum_t'(SP_NUM)) idx = SVC_BASE + int'(n) - SP_NUM;
                default:  idx = int'(n);
            endcase
        end
        if (n == rnum_t'(PC_NUM)) idx = 0;
        return slot_t'(idx);
    endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
    import bankrf_pkg::*;
(
    input  cpu_mode_e mode,
    input  rnum_t     num,
    output slot_t     slot,
    output logic      to_pc
);

    always_comb begin
        to_pc = (num == rnum_t'(PC_NUM));
        slot  = map_slot(mode, num);
    end

endmodule

// File: rtl/bank_storage.sv
module bank_storage #(
    parameter int DW    = 32,
    parameter int SLOTS = 26,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [DW-1:0] wr_data,
    input  logic          lk_en,
    input  logic [SW-1:0] lk_slot,
    input  logic [DW-1:0] lk_data,
    input  logic [SW-1:0] rd_a_slot,
    input  logic [SW-1:0] rd_b_slot,
    output logic [DW-1:0] rd_a_q,
    output logic [DW-1:0] rd_b_q
);

    typedef struct packed {
        logic [SLOTS-1:0][DW-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.regs[wr_slot] = wr_data;
        // link port is applied last so it wins a collision
        if (lk_en) st_d.regs[lk_slot] = lk_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_a_q = st_q.regs[rd_a_slot];
        rd_b_q = st_q.regs[rd_b_slot];
    end

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q == '0))
        else $error("storage not cleared by reset");

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(lk_en && lk_slot == wr_slot)) |=> (st_q.regs[$past(wr_slot)] == $past(wr_data)))
        else $error("normal write lost");

    assert_link_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> (st_q.regs[$past(lk_slot)] == $past(lk_data)))
        else $error("link write lost");

    assert_link_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lk_en && wr_slot == lk_slot) |=> (st_q.regs[$past(lk_slot)] == $past(lk_data)))
        else $error("link write did not win collision");

    for (genvar i = 0; i < SLOTS; i++) begin : g_hold
        assert_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_slot == SW'(i)) && !(lk_en && lk_slot == SW'(i)))
            |=> $stable(st_q.regs[i]))
            else $error("slot %0d changed without a write", i);
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [3:0]    rd_a_sel,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_sel,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          lnk_en,
    input  logic [1:0]    lnk_mode,
    input  logic [DW-1:0] lnk_data,
    input  logic [DW-1:0] pc_value,
    output logic          pc_wr_en,
    output logic [DW-1:0] pc_wr_data
);

    cpu_mode_e cur_mode;
    slot_t     slot_a, slot_b, slot_w, slot_l;
    logic      pc_a, pc_b, pc_w;
    logic      store_we;
    logic [DW-1:0] q_a, q_b;

    assign cur_mode = cpu_mode_e'(mode);

    bank_map i_map_a (.mode(cur_mode), .num(rd_a_sel), .slot(slot_a), .to_pc(pc_a));
    bank_map i_map_b (.mode(cur_mode), .num(rd_b_sel), .slot(slot_b), .to_pc(pc_b));
    bank_map i_map_w (.mode(cur_mode), .num(wr_sel),   .slot(slot_w), .to_pc(pc_w));

    always_comb begin
        slot_l     = map_slot(cpu_mode_e'(lnk_mode), rnum_t'(LR_NUM));
        store_we   = wr_en && !pc_w;
        pc_wr_en   = wr_en && pc_w;
        pc_wr_data = wr_data;
        rd_a_data  = pc_a ? pc_value : q_a;
        rd_b_data  = pc_b ? pc_value : q_b;
    end

    bank_storage #(.DW(DW), .SLOTS(PHYS_SLOTS)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (store_we),
        .wr_slot  (slot_w),
        .wr_data  (wr_data),
        .lk_en    (lnk_en),
        .lk_slot  (slot_l),
        .lk_data  (lnk_data),
        .rd_a_slot(slot_a),
        .rd_b_slot(slot_b),
        .rd_a_q   (q_a),
        .rd_b_q   (q_b)
    );

    assert_user_unbanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && rd_a_sel != 4'd15) |-> (int'(slot_a) == int'(rd_a_sel)))
        else $error("user mode reached banked storage");

    assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel < 4'd8) |-> (int'(slot_a) == int'(rd_a_sel)))
        else $error("low register banked");

    assert_pc_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 4'd15) |-> (pc_wr_en && !store_we))
        else $error("register 15 write reached storage");

    assert_pc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel != 4'd15) |-> !pc_wr_en)
        else $error("pc write raised for ordinary register");

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode, lnk_mode;
    logic [3:0]  rd_a_sel, rd_b_sel, wr_sel;
    logic [31:0] rd_a_data, rd_b_data, wr_data, lnk_data, pc_value, pc_wr_data;
    logic        wr_en, lnk_en, pc_wr_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    banked_regfile #(.DW(32)) i_banked_regfile (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lnk_en(lnk_en), .lnk_mode(lnk_mode), .lnk_data(lnk_data),
        .pc_value(pc_value), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  wm;
        logic [3:0]  ws;
        logic [31:0] wd;
        logic [1:0]  rm;
        logic [3:0]  rs;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 4'd3,  32'h11111111, 2'd3, 4'd3,  32'h11111111, 4'd2},  // R2
        '{1'b1, 2'd1, 4'd3,  32'h22222222, 2'd2, 4'd3,  32'h22222222, 4'd2},  // R2
        '{1'b1, 2'd0, 4'd9,  32'hA0A0A0A0, 2'd2, 4'd9,  32'hA0A0A0A0, 4'd3},  // R3
        '{1'b1, 2'd1, 4'd9,  32'hF9F9F9F9, 2'd0, 4'd9,  32'hA0A0A0A0, 4'd3},  // R3
        '{1'b0, 2'd0, 4'd0,  32'h0,        2'd1, 4'd9,  32'hF9F9F9F9, 4'd3},  // R3
        '{1'b1, 2'd3, 4'd12, 32'h5C5C5C5C, 2'd0, 4'd12, 32'h5C5C5C5C, 4'd3},  // R3
        '{1'b0, 2'd0, 4'd0,  32'h0,        2'd1, 4'd12, 32'h0,        4'd3},  // R3
        '{1'b1, 2'd2, 4'd13, 32'h13131313, 2'd0, 4'd13, 32'h0,        4'd4},  // R4
        '{1'b0, 2'd0, 4'd0,  32'h0,        2'd3, 4'd13, 32'h0,        4'd4},  // R4
        '{1'b0, 2'd0, 4'd0,  32'h0,        2'd1, 4'd13, 32'h0,        4'd4},  // R4
        '{1'b0, 2'd0, 4'd0,  32'h0,        2'd2, 4'd13, 32'h13131313, 4'd4},  // R4
        '{1'b1, 2'd0, 4'd14, 32'hEEEE0000, 2'd3, 4'd14, 32'h0,        4'd4},  // R4
        '{1'b1, 2'd3, 4'd14, 32'h5E5E5E5E, 2'd0, 4'd14, 32'hEEEE0000, 4'd4}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [3:0] r, input logic [31:0] d);
        @(negedge clk);
        mode = m; wr_sel = r; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [1:0] m, input logic [3:0] r,
                        input logic [31:0] exp);
        @(negedge clk);
        wr_en = 1'b0; lnk_en = 1'b0;
        mode = m; rd_a_sel = r; rd_b_sel = r;
        #1;
        chk({tag, " port A"}, rd_a_data, exp);
        chk({tag, " port B"}, rd_b_data, exp);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd0; rd_a_sel = 4'd0; rd_b_sel = 4'd0;
        wr_en = 1'b0; wr_sel = 4'd0; wr_data = '0;
        lnk_en = 1'b0; lnk_mode = 2'd0; lnk_data = '0; pc_value = 32'hCAFE0004;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every register is zero in every mode after reset
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 15; r++)
                peek("R1 reset", 2'(m), 4'(r), 32'h0);

        // table walk (R2, R3, R4)
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].wm, VECS[i].ws, VECS[i].wd);
            peek($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].rm, VECS[i].rs, VECS[i].exp);
        end

        // R5: same-cycle read shows old value, new value after the edge
        @(negedge clk);
        mode = 2'd0; rd_a_sel = 4'd5; wr_sel = 4'd5; wr_data = 32'h00000055; wr_en = 1'b1;
        #1 chk("R5 read during write", rd_a_data, 32'h0);
        @(posedge clk);
        #1 wr_en = 1'b0;
        chk("R5 read after edge", rd_a_data, 32'h00000055);

        // R6: link write to IRQ R14 from user mode, alongside a normal write
        @(negedge clk);
        mode = 2'd0; wr_sel = 4'd2; wr_data = 32'h00002222; wr_en = 1'b1;
        lnk_en = 1'b1; lnk_mode = 2'd2; lnk_data = 32'h00001EAF;
        @(posedge clk);
        #1 begin wr_en = 1'b0; lnk_en = 1'b0; end
        peek("R6 irq link", 2'd2, 4'd14, 32'h00001EAF);
        peek("R6 user lr kept", 2'd0, 4'd14, 32'hEEEE0000);
        peek("R6 svc lr kept", 2'd3, 4'd14, 32'h5E5E5E5E);
        peek("R6 normal write", 2'd0, 4'd2, 32'h00002222);

        // R7: collision on SVC R14, link data wins
        @(negedge clk);
        mode = 2'd3; wr_sel = 4'd14; wr_data = 32'h0000AAAA; wr_en = 1'b1;
        lnk_en = 1'b1; lnk_mode = 2'd3; lnk_data = 32'h0000BBBB;
        @(posedge clk);
        #1 begin wr_en = 1'b0; lnk_en = 1'b0; end
        peek("R7 collision", 2'd3, 4'd14, 32'h0000BBBB);

        // R6: link into FIQ R14 while in SVC mode
        @(negedge clk);
        mode = 2'd3; lnk_en = 1'b1; lnk_mode = 2'd1; lnk_data = 32'h00000F14;
        @(posedge clk);
        #1 lnk_en = 1'b0;
        peek("R6 fiq link", 2'd1, 4'd14, 32'h00000F14);
        peek("R6 svc untouched", 2'd3, 4'd14, 32'h0000BBBB);

        // R8: register 15 read and write pass through
        @(negedge clk);
        mode = 2'd2; rd_a_sel = 4'd15; rd_b_sel = 4'd15;
        wr_sel = 4'd15; wr_data = 32'h0000DEAD; wr_en = 1'b1;
        #1;
        chk("R8 pc read A", rd_a_data, 32'hCAFE0004);
        chk("R8 pc read B", rd_b_data, 32'hCAFE0004);
        chk("R8 pc write enable", 32'(pc_wr_en), 32'h1);
        chk("R8 pc write data", pc_wr_data, 32'h0000DEAD);
        @(posedge clk);
        #1 wr_en = 1'b0;
        for (int r = 0; r < 15; r++)
            peek("R8 no store", 2'd2, 4'(r),
                 r == 2  ? 32'h00002222 : r == 3  ? 32'h22222222 :
                 r == 5  ? 32'h00000055 : r == 9  ? 32'hA0A0A0A0 :
                 r == 12 ? 32'h5C5C5C5C : r == 13 ? 32'h13131313 :
                 r == 14 ? 32'h00001EAF : 32'h0);
        @(negedge clk);
        mode = 2'd0; wr_sel = 4'd7; wr_data = 32'h77; wr_en = 1'b1;
        #1 chk("R8 pc quiet", 32'(pc_wr_en), 32'h0);
        @(posedge clk);
        #1 wr_en = 1'b0;

        // R9: disabled write changes nothing
        @(negedge clk);
        mode = 2'd0; wr_sel = 4'd3; wr_data = 32'h00000BAD; wr_en = 1'b0; lnk_en = 1'b0;
        @(posedge clk);
        peek("R9 no write", 2'd0, 4'd3, 32'h22222222);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        peek("R1 rereset user", 2'd0, 4'd3, 32'h0);
        peek("R1 rereset fiq", 2'd1, 4'd9, 32'h0);
        peek("R1 rereset irq", 2'd2, 4'd13, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule